// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a shared serial clock. Each character goes out least significant bit first. There are no start, stop or parity bits. The transmit line changes on each falling edge of the serial clock. The receive line is sampled on each rising edge.

The serial clock has two possible sources. The first is an internal divider of the system clock, and in that case the block drives the clock out. The second is an external clock input, which the block synchronises and follows. Both the transmit and receive paths have a holding buffer in front of or behind the shifter. Software can therefore queue the next character, or collect the last one, while a shift is running. Queued characters follow each other with no idle clock period between them.

A host writes characters with a one-cycle strobe and reads received characters with another strobe. It watches four flags: transmit buffer empty, transmit finished, receive full and receive overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A character leaves on `txd_o` as 8 bits, bit 0 first and bit 7 last. With the internal clock, `txd_o` changes only in the system cycle where `sck_o` falls.
- R2: `rxd_i` is sampled at each rising serial-clock edge. Eight samples, the first being bit 0, form a character. When it completes into an empty receive buffer, it appears on `rx_data_o` and `rx_full_o` is set.
- R3: With the internal clock, each character gets exactly 8 low pulses on `sck_o` and `sck_oe_o` is 1. Each clock half period lasts `baud_div_i`+1 system cycles. `sck_o` rests high whenever nothing is pending.
- R4: After the last bit, `txd_o` keeps the value of bit 7 until the next character starts.
- R5: When `clk_sel_i` bit 1 is 1, the external clock `sck_ext_i` drives both shifters and `sck_oe_o` is 0. When bit 1 is 0, the internal clock is used. Bit 0 has no effect.
- R6: A write is accepted only while `tx_empty_o` is 1, and it clears `tx_empty_o` on the next edge. The buffered character moves to the shifter at the next falling serial-clock edge, which sets `tx_empty_o` again. A write while the buffer is full is ignored.
- R7: If a character is waiting when a frame ends, its first falling edge comes `baud_div_i`+1 system cycles after the last rising edge. No extra high period is inserted.
- R8: `tx_end_o` is 0 from an accepted write until the buffer is empty and the rising edge after the final bit has passed. It then returns to 1.
- R9: If a character completes while `rx_full_o` is 1, `rx_ovr_o` is set and `rx_data_o` keeps its value. A pulse on `rx_rd_i` clears both `rx_full_o` and `rx_ovr_o`.
- R10: After reset: `sck_o`=1, `txd_o`=1, `tx_empty_o`=1, `tx_end_o`=1, `rx_full_o`=0, `rx_ovr_o`=0 and `rx_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | Clock source; bit 1 set selects the external clock |
| baud_div_i | input | DIV_W | Internal half-period length minus one, in system cycles |
| sck_ext_i | input | 1 | External serial clock |
| sck_o | output | 1 | Serial clock out (internal mode) |
| sck_oe_o | output | 1 | Output enable for `sck_o` |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| tx_wr_i | input | 1 | Write strobe for the transmit buffer |
| tx_data_i | input | DATA_W | Character to transmit |
| tx_empty_o | output | 1 | Transmit buffer can take a character |
| tx_end_o | output | 1 | Transmitter fully idle |
| rx_rd_i | input | 1 | Read strobe; clears receive full and overrun |
| rx_data_o | output | DATA_W | Last received character |
| rx_full_o | output | 1 | Unread character in the receive buffer |
| rx_ovr_o | output | 1 | A character was lost to a full buffer |

## Verification
With the internal clock, `sck_o` and `txd_o` change on the same system edge. The receive flags and data change on the edge where `sck_o` goes high for the eighth time. The bench samples at the falling system edge and waits one further cycle after `tx_end_o` rises before it reads its bit capture. A write takes effect on the flags one edge later, so flag checks follow the write strobe by one cycle. With the external clock, edges reach the shifters two to three system cycles late because of the synchroniser. The bench therefore holds each external level for eight cycles, and it reads `txd_o` and the receive outputs only once that margin has passed.

// File: rtl/sss_pkg.sv
package sss_pkg;
   typedef enum logic [1:0] {
      CKSRC_INT_A = 2'b00,
      CKSRC_INT_B = 2'b01,
      CKSRC_EXT_A = 2'b10,
      CKSRC_EXT_B = 2'b11
   } cksrc_e;

   function automatic logic cksrc_is_ext(input cksrc_e sel);
      logic ext;
      case (sel)
         CKSRC_EXT_A, CKSRC_EXT_B: ext = 1'b1;
         default:                  ext = 1'b0;
      endcase
      return ext;
   endfunction
endpackage

// File: rtl/sss_sck_gen.sv
module sss_sck_gen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ext_sel_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   input  logic             sck_ext_i,
   output logic             sck_o,
   output logic             sck_oe_o,
   output logic             rise_stb_o,
   output logic             fall_stb_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             sck_q;
   logic             int_tick, int_rise, int_fall;
   logic             ext_rise, ext_fall;

   // internal divider: toggles every div_i+1 cycles, parks high when idle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (ext_sel_i || (sck_q && !run_i)) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (cnt_q == div_i) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign int_tick = !ext_sel_i && (cnt_q == div_i) && (run_i || !sck_q);
   assign int_fall = int_tick && sck_q;
   assign int_rise = int_tick && !sck_q;

   generate
      if (EXT_CLK_EN) begin : g_ext
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   last_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sync_q <= '1;
               last_q <= 1'b1;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], sck_ext_i};
               last_q <= sync_q[SYNC_STAGES-1];
            end
         end
         assign ext_rise = ext_sel_i &&  sync_q[SYNC_STAGES-1] && !last_q;
         assign ext_fall = ext_sel_i && !sync_q[SYNC_STAGES-1] &&  last_q;
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = sck_ext_i;
         assign ext_rise   = 1'b0;
         assign ext_fall   = 1'b0;
      end
   endgenerate

   assign rise_stb_o = ext_sel_i ? ext_rise : int_rise;
   assign fall_stb_o = ext_sel_i ? ext_fall : int_fall;
   assign sck_o      = sck_q;
   assign sck_oe_o   = !ext_sel_i;

   AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_sel_i && sck_q && !run_i) |=> sck_q); // R3
   AST_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_sel_i && $changed(div_i) == 1'b0 && !int_tick && $past(!ext_sel_i)) |=> $stable(sck_q)); // R3
endmodule

// File: rtl/sss_tx.sv
module sss_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              fall_stb_i,
   input  logic              rise_stb_i,
   output logic              txd_o,
   output logic              buf_empty_o,
   output logic              tx_end_o,
   output logic              run_o
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] buf_q, sh_q;
   logic              buf_full_q, frame_q, txd_q;
   logic [CNT_W-1:0]  left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_q      <= '0;
         buf_full_q <= 1'b0;
         sh_q       <= '0;
         left_q     <= '0;
         frame_q    <= 1'b0;
         txd_q      <= 1'b1;
      end else begin
         if (fall_stb_i) begin
            if (left_q != '0) begin
               txd_q  <= sh_q[0];
               sh_q   <= {1'b0, sh_q[DATA_W-1:1]};
               left_q <= left_q - CNT_W'(1);
            end else if (buf_full_q) begin
               txd_q      <= buf_q[0];
               sh_q       <= {1'b0, buf_q[DATA_W-1:1]};
               left_q     <= LAST_IDX;
               buf_full_q <= 1'b0;
               frame_q    <= 1'b1;
            end
         end
         if (rise_stb_i && frame_q && left_q == '0) begin
            frame_q <= 1'b0;
         end
         if (wr_i && !buf_full_q) begin
            buf_q      <= wdata_i;
            buf_full_q <= 1'b1;
         end
      end
   end

   assign txd_o       = txd_q;
   assign buf_empty_o = !buf_full_q;
   assign tx_end_o    = !buf_full_q && !frame_q;
   assign run_o       = buf_full_q || frame_q;

   AST_TXD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fall_stb_i |=> $stable(txd_q)); // R1
   AST_LEFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      left_q <= LAST_IDX); // R1
   AST_WR_FULL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && buf_full_q) |=> $stable(buf_q)); // R6
   AST_END_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_end_o) |-> $past(rise_stb_i)); // R8
endmodule

// File: rtl/sss_rx.sv
module sss_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rise_stb_i,
   input  logic              rxd_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o,
   output logic              ovr_o
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q, data_q, word;
   logic [CNT_W-1:0]  cnt_q;
   logic              full_q, ovr_q, done;

   assign done = rise_stb_i && (cnt_q == LAST_IDX);
   assign word = {rxd_i, sh_q[DATA_W-1:1]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (rise_stb_i) begin
            sh_q  <= word;
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
         end
         if (rd_i) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         if (done) begin
            if (full_q && !rd_i) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= word;
               full_q <= 1'b1;
            end
         end
      end
   end

   assign data_o = data_q;
   assign full_o = full_q;
   assign ovr_o  = ovr_q;

   AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done && full_q && !rd_i) |=> ($stable(data_q) && ovr_q)); // R9
   AST_FULL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done && !full_q) |=> full_q); // R2
   AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !done) |=> (!full_q && !ovr_q)); // R9
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        clk_sel_i,
   input  logic [DIV_W-1:0]  baud_div_i,
   input  logic              sck_ext_i,
   output logic              sck_o,
   output logic              sck_oe_o,
   output logic              txd_o,
   input  logic              rxd_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_empty_o,
   output logic              tx_end_o,
   input  logic              rx_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_full_o,
   output logic              rx_ovr_o
);
   import sss_pkg::*;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (DIV_W >= 1) else $error("DIV_W must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic ext_sel, run, rise_stb, fall_stb;

   assign ext_sel = EXT_CLK_EN && cksrc_is_ext(cksrc_e'(clk_sel_i));

   sss_sck_gen #(
      .DIV_W      (DIV_W),
      .SYNC_STAGES(SYNC_STAGES),
      .EXT_CLK_EN (EXT_CLK_EN)
   ) sck_gen_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ext_sel_i (ext_sel),
      .div_i     (baud_div_i),
      .run_i     (run),
      .sck_ext_i (sck_ext_i),
      .sck_o     (sck_o),
      .sck_oe_o  (sck_oe_o),
      .rise_stb_o(rise_stb),
      .fall_stb_o(fall_stb)
   );

   sss_tx #(.DATA_W(DATA_W)) tx_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (tx_wr_i),
      .wdata_i    (tx_data_i),
      .fall_stb_i (fall_stb),
      .rise_stb_i (rise_stb),
      .txd_o      (txd_o),
      .buf_empty_o(tx_empty_o),
      .tx_end_o   (tx_end_o),
      .run_o      (run)
   );

   sss_rx #(.DATA_W(DATA_W)) rx_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_stb_i(rise_stb),
      .rxd_i     (rxd_i),
      .rd_i      (rx_rd_i),
      .data_o    (rx_data_o),
      .full_o    (rx_full_o),
      .ovr_o     (rx_ovr_o)
   );

   AST_NO_DUAL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_stb && fall_stb)); // R1
   AST_EXT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_sel && $past(ext_sel)) |-> sck_o); // R5
endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic [7:0] div = 8'd1;
   logic       sck_ext = 1'b1;
   logic       sck_o, sck_oe, txd;
   logic       rxd_drv = 1'b1;
   logic       loop_en = 1'b1;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_empty, tx_end;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, rx_ovr;
   logic       rxd;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign rxd = loop_en ? txd : rxd_drv;

   sync_serial_xcvr dut_i (
      .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .baud_div_i(div),
      .sck_ext_i(sck_ext), .sck_o(sck_o), .sck_oe_o(sck_oe), .txd_o(txd),
      .rxd_i(rxd), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_empty_o(tx_empty),
      .tx_end_o(tx_end), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
      .rx_full_o(rx_full), .rx_ovr_o(rx_ovr)
   );

   // monitor of the internal serial clock
   int         mon_falls = 0;
   int         mon_rises = 0;
   int         mon_glitch = 0;
   logic [7:0] mon_cap = 8'h00;
   logic       prev_sck = 1'b1;
   logic       prev_txd = 1'b1;
   always @(negedge clk) begin
      if (rst_n && !clk_sel[1]) begin
         if (txd != prev_txd && !(prev_sck && !sck_o)) mon_glitch++;
         if (prev_sck && !sck_o) mon_falls++;
         if (!prev_sck && sck_o) begin
            mon_rises++;
            mon_cap = {txd, mon_cap[7:1]};
         end
      end
      prev_sck = sck_o;
      prev_txd = txd;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_char(input logic [7:0] b);
      @(negedge clk);
      tx_wr = 1'b1;
      tx_data = b;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic read_pulse();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic wait_tx_end();
      for (int i = 0; i < 5000 && !tx_end; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic ext_frame(input logic [7:0] rx_b, output logic [7:0] cap);
      cap = 8'h00;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         sck_ext = 1'b0;
         rxd_drv = rx_b[i];
         repeat (8) @(negedge clk);
         cap = {txd, cap[7:1]};
         sck_ext = 1'b1;
         repeat (8) @(negedge clk);
      end
   endtask

   // stimulus table: {clock select, divider, character}
   localparam int NVEC = 6;
   localparam logic [17:0] VEC [NVEC] = '{
      {2'b00, 8'd1, 8'hA5},
      {2'b01, 8'd0, 8'h3C},
      {2'b00, 8'd3, 8'h80},
      {2'b00, 8'd2, 8'h01},
      {2'b01, 8'd5, 8'hFF},
      {2'b00, 8'd0, 8'h00}
   };

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] cap;
      int f0, r0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(sck_o == 1'b1 && txd == 1'b1, "R10 sck/txd idle", {sck_o, txd}, 2'b11);
      check(tx_empty && tx_end && !rx_full && !rx_ovr, "R10 flags",
            {tx_empty, tx_end, rx_full, rx_ovr}, 4'b1100);
      check(rx_data == 8'h00, "R10 rx_data", rx_data, 0);

      // table walk: one character each, loopback to the receiver
      for (int v = 0; v < NVEC; v++) begin
         clk_sel = VEC[v][17:16];
         div     = VEC[v][15:8];
         @(negedge clk);
         f0 = mon_falls;
         r0 = mon_rises;
         write_char(VEC[v][7:0]);
         check(!tx_end, "R8 tx_end low after write", tx_end, 0);
         wait_tx_end();
         check(mon_cap == VEC[v][7:0], "R1 bits LSB first", mon_cap, VEC[v][7:0]);
         check(mon_falls - f0 == 8 && mon_rises - r0 == 8, "R3 eight pulses",
               mon_falls - f0, 8);
         check(sck_oe == 1'b1, "R3 clock driven", sck_oe, 1);
         check(txd == VEC[v][7], "R4 line holds MSB", txd, VEC[v][7]);
         check(rx_full && rx_data == VEC[v][7:0], "R2 received char", rx_data, VEC[v][7:0]);
         repeat (20) @(negedge clk);
         check(sck_o == 1'b1 && mon_falls - f0 == 8, "R3 clock rests high",
               mon_falls - f0, 8);
         check(txd == VEC[v][7], "R4 MSB held while idle", txd, VEC[v][7]);
         read_pulse();
         check(!rx_full && !rx_ovr, "R9 read clears", {rx_full, rx_ovr}, 0);
      end
      check(mon_glitch == 0, "R1 txd moves only at falling sck", mon_glitch, 0);

      // back-to-back, ignored write, overrun
      begin
         int falls, maxhi, hirun;
         logic pv;
         clk_sel = 2'b00;
         div = 8'd2;
         write_char(8'h5A);
         check(!tx_empty, "R6 buffer taken", tx_empty, 0);
         for (int i = 0; i < 100 && !tx_empty; i++) @(negedge clk);
         write_char(8'hC3);
         write_char(8'h99);
         falls = 0; maxhi = 0; hirun = 0; pv = sck_o;
         for (int i = 0; i < 2000 && !tx_end; i++) begin
            @(negedge clk);
            if (pv && !sck_o) begin
               falls++;
               if (hirun > maxhi) maxhi = hirun;
            end
            if (!pv && sck_o) hirun = 0;
            if (sck_o) hirun++;
            pv = sck_o;
         end
         @(negedge clk);
         check(falls == 15, "R7 continuous falls", falls, 15);
         check(maxhi == 3, "R7 no extra high period", maxhi, 3);
         check(mon_cap == 8'hC3, "R6 write while full ignored", mon_cap, 8'hC3);
         check(rx_ovr && rx_full, "R9 overrun flagged", {rx_full, rx_ovr}, 2'b11);
         check(rx_data == 8'h5A, "R9 data kept on overrun", rx_data, 8'h5A);
         check(tx_end && tx_empty, "R8 tx_end after last rise", {tx_end, tx_empty}, 2'b11);
         read_pulse();
         check(!rx_full && !rx_ovr, "R9 read clears overrun", {rx_full, rx_ovr}, 0);
      end

      // external clock, both select codes with bit 1 set
      loop_en = 1'b0;
      clk_sel = 2'b10;
      repeat (4) @(negedge clk);
      check(sck_oe == 1'b0, "R5 clock not driven", sck_oe, 0);
      write_char(8'h6E);
      ext_frame(8'hB1, cap);
      repeat (8) @(negedge clk);
      check(cap == 8'h6E, "R5 external tx", cap, 8'h6E);
      check(rx_full && rx_data == 8'hB1, "R5 external rx", rx_data, 8'hB1);
      check(txd == 1'b0, "R4 MSB held external", txd, 0);
      check(tx_end, "R8 idle after external frame", tx_end, 1);
      read_pulse();
      clk_sel = 2'b11;
      repeat (4) @(negedge clk);
      check(sck_oe == 1'b0 && sck_o == 1'b1, "R5 bit0 no effect", {sck_oe, sck_o}, 2'b01);
      write_char(8'h93);
      ext_frame(8'h4D, cap);
      repeat (8) @(negedge clk);
      check(cap == 8'h93, "R5 external tx alt code", cap, 8'h93);
      check(rx_full && rx_data == 8'h4D, "R2 external rx alt code", rx_data, 8'h4D);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule